// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block gives a processor three byte-wide general-purpose ports, named A, B and C, on a small register interface. The interface is an 8-bit data bus, a 2-bit address, a chip select and separate read and write strobes. Writes are sampled on the rising clock edge when chip select and the write strobe are both high. Reads are combinational and are valid while chip select and the read strobe are high.

The direction of port A, of port B and of each half of port C is set by a configuration word written to the control address. The same address also accepts a command that forces a single port C line to 0 or 1, and bit 7 of the written byte picks which of the two meanings applies.

Values written to output ports are held in latches, and each latch drives its pins continuously. Pins configured as inputs are not captured: a read returns their level at that moment. Every pin has an output-enable that follows its port's direction.

Top module: `pio3port`

## Requirements
- R1: After reset all output-enables are 0, all output latches hold 0x00, and reads of ports A, B and C return the live pins.
- R2: A write with address 0 loads the port A latch, address 1 loads the port B latch, and address 2 loads all eight bits of the port C latch.
- R3: A write to address 3 with bit 7 = 1 and bits 6, 5 and 2 all 0 is a configuration word. In that word, bit 4 sets the direction of A, bit 3 sets C[7:4], bit 1 sets B and bit 0 sets C[3:0], with 1 meaning input. Each output-enable is high exactly when its port or nibble is an output.
- R4: Accepting a configuration word clears the A, B and C latches to 0x00 on the same edge.
- R5: A write to address 3 with bit 7 = 1 and any of bits 6, 5 or 2 set changes neither the directions nor the latches.
- R6: A write to address 3 with bit 7 = 0 sets port C line number bits[3:1] to the value of bit 0. It leaves the other C lines and all directions unchanged, and bits 6:4 have no effect.
- R7: Reading an input-configured port, or an input-configured nibble of port C, returns the pin levels present during the read, with no latching.
- R8: Reading an output-configured port, or an output-configured nibble of port C, returns the latch contents.
- R9: A read of address 3 returns 0x00. The read bus is 0x00 whenever chip select and the read strobe are not both high.
- R10: A write strobe without chip select changes no latch and no direction.
- R11: The two halves of port C take independent directions, so a single port C read can mix pin levels in one nibble with latch contents in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| rdStrobe | input | 1 | Read strobe, active high |
| wrStrobe | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wrData | input | 8 | Write data bus |
| rdData | output | 8 | Read data bus |
| pinInA | input | 8 | Port A pin levels |
| pinInB | input | 8 | Port B pin levels |
| pinInC | input | 8 | Port C pin levels |
| pinOutA | output | 8 | Port A latch drive |
| pinOutB | output | 8 | Port B latch drive |
| pinOutC | output | 8 | Port C latch drive |
| pinOeA | output | 8 | Port A output-enables |
| pinOeB | output | 8 | Port B output-enables |
| pinOeC | output | 8 | Port C output-enables |

## Verification
The bench sets port C to split directions in both orders and reads back a mix of pin levels and latch bits. A design that treats C as one port, or swaps the nibbles, returns the wrong half. It sends configuration words with bit 6, bit 5 or bit 2 set, and a design that accepts them would clear port C or change the output-enables. Set/clear commands go to lines 0, 5 and 7, with junk in bits 6:4, to catch a wrong index field or disturbed neighbouring lines. Further tests change input pins while a read is held, which exposes any latching of inputs, and write with chip select low.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW        = 8;
  localparam int HALF      = DW / 2;
  localparam int IDXW      = $clog2(DW);
  localparam int AW        = 2;

  localparam logic [AW-1:0] ADDR_A    = 2'd0;
  localparam logic [AW-1:0] ADDR_B    = 2'd1;
  localparam logic [AW-1:0] ADDR_C    = 2'd2;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd3;

  // configuration-word bit positions
  localparam int CW_FLAG  = 7;
  localparam int CW_RSV6  = 6;
  localparam int CW_RSV5  = 5;
  localparam int CW_DIRA  = 4;
  localparam int CW_DIRCH = 3;
  localparam int CW_RSV2  = 2;
  localparam int CW_DIRB  = 1;
  localparam int CW_DIRCL = 0;

  // 1 = input
  typedef struct packed {
    logic inA;
    logic inB;
    logic inCHi;
    logic inCLo;
  } dirT;

  typedef struct packed {
    logic            wrA;
    logic            wrB;
    logic            wrC;
    logic            cfgLoad;
    logic            bitOp;
    logic [IDXW-1:0] bitIdx;
    logic            bitVal;
    logic [DW-1:0]   data;
  } strobeT;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          wrStrobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output dirT           dir,
  output strobeT        stb
);
  logic wrHit;
  logic ctrlHit;
  logic cfgLegal;

  assign wrHit    = cs & wrStrobe;
  assign ctrlHit  = wrHit && (addr == ADDR_CTRL);
  assign cfgLegal = wrData[CW_FLAG] &
                    ~(wrData[CW_RSV6] | wrData[CW_RSV5] | wrData[CW_RSV2]);

  always_comb begin
    stb         = '0;
    stb.data    = wrData;
    stb.wrA     = wrHit && (addr == ADDR_A);
    stb.wrB     = wrHit && (addr == ADDR_B);
    stb.wrC     = wrHit && (addr == ADDR_C);
    stb.cfgLoad = ctrlHit & cfgLegal;
    stb.bitOp   = ctrlHit & ~wrData[CW_FLAG];
    stb.bitIdx  = wrData[IDXW:1];
    stb.bitVal  = wrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dir <= '{inA: 1'b1, inB: 1'b1, inCHi: 1'b1, inCLo: 1'b1};
    end else if (stb.cfgLoad) begin
      dir.inA   <= wrData[CW_DIRA];
      dir.inB   <= wrData[CW_DIRB];
      dir.inCHi <= wrData[CW_DIRCH];
      dir.inCLo <= wrData[CW_DIRCL];
    end
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  dirT           dir,
  input  logic          cs,
  input  logic          rdStrobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] pinInA,
  input  logic [DW-1:0] pinInB,
  input  logic [DW-1:0] pinInC,
  output logic [DW-1:0] pinOutA,
  output logic [DW-1:0] pinOutB,
  output logic [DW-1:0] pinOutC,
  output logic [DW-1:0] pinOeA,
  output logic [DW-1:0] pinOeB,
  output logic [DW-1:0] pinOeC,
  output logic [DW-1:0] rdData
);
  localparam int NPORT = 3;

  logic [DW-1:0] latA, latB, latC;
  logic [DW-1:0] oeVec  [NPORT];
  logic [DW-1:0] latVec [NPORT];
  logic [DW-1:0] pinVec [NPORT];
  logic [DW-1:0] view   [NPORT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else if (stb.cfgLoad) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (stb.wrA) latA <= stb.data;
      if (stb.wrB) latB <= stb.data;
      if (stb.wrC) latC <= stb.data;
      else if (stb.bitOp) latC[stb.bitIdx] <= stb.bitVal;
    end
  end

  assign oeVec[0]  = {DW{~dir.inA}};
  assign oeVec[1]  = {DW{~dir.inB}};
  assign oeVec[2]  = {{HALF{~dir.inCHi}}, {HALF{~dir.inCLo}}};
  assign latVec[0] = latA;
  assign latVec[1] = latB;
  assign latVec[2] = latC;
  assign pinVec[0] = pinInA;
  assign pinVec[1] = pinInB;
  assign pinVec[2] = pinInC;

  for (genvar p = 0; p < NPORT; p++) begin : g_view
    assign view[p] = (oeVec[p] & latVec[p]) | (~oeVec[p] & pinVec[p]);
  end

  assign pinOutA = latA;
  assign pinOutB = latB;
  assign pinOutC = latC;
  assign pinOeA  = oeVec[0];
  assign pinOeB  = oeVec[1];
  assign pinOeC  = oeVec[2];

  always_comb begin
    rdData = '0;
    if (cs && rdStrobe) begin
      unique case (addr)
        ADDR_A:  rdData = view[0];
        ADDR_B:  rdData = view[1];
        ADDR_C:  rdData = view[2];
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio3port.sv
module pio3port
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          rdStrobe,
  input  logic          wrStrobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] pinInA,
  input  logic [DW-1:0] pinInB,
  input  logic [DW-1:0] pinInC,
  output logic [DW-1:0] pinOutA,
  output logic [DW-1:0] pinOutB,
  output logic [DW-1:0] pinOutC,
  output logic [DW-1:0] pinOeA,
  output logic [DW-1:0] pinOeB,
  output logic [DW-1:0] pinOeC
);
  dirT    dir;
  strobeT stb;

  pio_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cs       (cs),
    .wrStrobe (wrStrobe),
    .addr     (addr),
    .wrData   (wrData),
    .dir      (dir),
    .stb      (stb)
  );

  pio_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dir      (dir),
    .cs       (cs),
    .rdStrobe (rdStrobe),
    .addr     (addr),
    .pinInA   (pinInA),
    .pinInB   (pinInB),
    .pinInC   (pinInC),
    .pinOutA  (pinOutA),
    .pinOutB  (pinOutB),
    .pinOutC  (pinOutC),
    .pinOeA   (pinOeA),
    .pinOeB   (pinOeB),
    .pinOeC   (pinOeC),
    .rdData   (rdData)
  );
endmodule

// File: rtl/pio_checker.sv
module pio_checker
  import pio_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          cs,
  input logic          rdStrobe,
  input logic          wrStrobe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdData,
  input logic [DW-1:0] pinOutA,
  input logic [DW-1:0] pinOutB,
  input logic [DW-1:0] pinOutC,
  input logic [DW-1:0] pinOeA,
  input logic [DW-1:0] pinOeB,
  input logic [DW-1:0] pinOeC
);
  logic ctrlWr;
  assign ctrlWr = cs && wrStrobe && (addr == ADDR_CTRL);

  // R3: enables are uniform across a port or nibble
  a_r3_oe_uniform: assert property (@(posedge clk) disable iff (!rstN)
    (pinOeA == '0 || pinOeA == '1) && (pinOeB == '0 || pinOeB == '1) &&
    (pinOeC[DW-1:HALF] == '0 || pinOeC[DW-1:HALF] == '1) &&
    (pinOeC[HALF-1:0] == '0 || pinOeC[HALF-1:0] == '1));

  // R4
  a_r4_cfg_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[7] && !wrData[6] && !wrData[5] && !wrData[2]) |=>
    (pinOutA == '0 && pinOutB == '0 && pinOutC == '0));

  // R5
  a_r5_bad_cfg_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[7] && (wrData[6] || wrData[5] || wrData[2])) |=>
    ($stable(pinOutA) && $stable(pinOutB) && $stable(pinOutC) &&
     $stable(pinOeA) && $stable(pinOeB) && $stable(pinOeC)));

  // R6: target line takes the value
  a_r6_bit_value: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[7]) |=> (pinOutC[$past(wrData[3:1])] == $past(wrData[0])));

  // R6: neighbours and directions untouched
  a_r6_bit_others: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[7]) |=>
    ((((pinOutC ^ $past(pinOutC)) & ~(8'h01 << $past(wrData[3:1]))) == '0) &&
     $stable(pinOeA) && $stable(pinOeB) && $stable(pinOeC)));

  // R10
  a_r10_no_cs: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> ($stable(pinOutA) && $stable(pinOutB) && $stable(pinOutC) &&
             $stable(pinOeC)));

  // R9
  a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!(cs && rdStrobe) || addr == ADDR_CTRL) |-> (rdData == '0));
endmodule

bind pio3port pio_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cs       (cs),
  .rdStrobe (rdStrobe),
  .wrStrobe (wrStrobe),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .pinOutA  (pinOutA),
  .pinOutB  (pinOutB),
  .pinOutC  (pinOutC),
  .pinOeA   (pinOeA),
  .pinOeB   (pinOeB),
  .pinOeC   (pinOeC)
);

// File: tb/test_pio3port.sv
`timescale 1ns/1ps
module test_pio3port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] pinInA = '0, pinInB = '0, pinInC = '0;
  logic [7:0] pinOutA, pinOutB, pinOutC, pinOeA, pinOeB, pinOeC;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio3port i_pio3port (
    .clk(clk), .rstN(rstN), .cs(cs), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .pinInA(pinInA), .pinInB(pinInB), .pinInC(pinInC),
    .pinOutA(pinOutA), .pinOutB(pinOutB), .pinOutC(pinOutC),
    .pinOeA(pinOeA), .pinOeB(pinOeB), .pinOeC(pinOeC)
  );

  // {isWrite, addr, data, pin level on all ports, expected read}
  localparam int NV = 36;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0,2'd0,8'h00,8'h5A,8'h5A},
    {1'b1,2'd3,8'h80,8'h00,8'h00},
    {1'b1,2'd0,8'h3C,8'h00,8'h00},
    {1'b1,2'd1,8'hC3,8'h00,8'h00},
    {1'b1,2'd2,8'h96,8'h00,8'h00},
    {1'b0,2'd0,8'h00,8'hFF,8'h3C},
    {1'b0,2'd1,8'h00,8'h00,8'hC3},
    {1'b0,2'd2,8'h00,8'h00,8'h96},
    {1'b1,2'd3,8'h89,8'h00,8'h00},
    {1'b0,2'd0,8'h00,8'hFF,8'h00},
    {1'b0,2'd2,8'h00,8'hA5,8'hA5},
    {1'b1,2'd3,8'h88,8'h00,8'h00},
    {1'b1,2'd2,8'h0F,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h70,8'h7F},
    {1'b1,2'd3,8'h81,8'h00,8'h00},
    {1'b1,2'd2,8'hA0,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h05,8'hA5},
    {1'b1,2'd3,8'h92,8'h00,8'h00},
    {1'b0,2'd0,8'h00,8'h11,8'h11},
    {1'b0,2'd1,8'h00,8'h22,8'h22},
    {1'b0,2'd2,8'h00,8'hFF,8'h00},
    {1'b1,2'd3,8'h0B,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'h20},
    {1'b1,2'd3,8'h01,8'h00,8'h00},
    {1'b1,2'd3,8'h0F,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'hA1},
    {1'b1,2'd3,8'h7A,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'h81},
    {1'b0,2'd3,8'h00,8'hFF,8'h00},
    {1'b1,2'd3,8'hC0,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'h81},
    {1'b0,2'd0,8'h00,8'h33,8'h33},
    {1'b1,2'd3,8'h84,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'h81},
    {1'b1,2'd3,8'hA0,8'h00,8'h00},
    {1'b0,2'd2,8'h00,8'h00,8'h81}
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wrStrobe = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    cs = 1'b0; wrStrobe = 1'b0;
  endtask

  task automatic busReadCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1'b1; rdStrobe = 1'b1; addr = a;
    #1 check(rdData, exp, tag);
    cs = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic setPins(input logic [7:0] v);
    pinInA = v; pinInB = v; pinInC = v;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pinOeA | pinOeB | pinOeC, 8'h00, "R1 enables after reset");
    check(pinOutA | pinOutB | pinOutC, 8'h00, "R1 latches after reset");
    setPins(8'h6E);
    busReadCheck(2'd1, 8'h6E, "R1 B reads pins after reset");
    // R9 idle bus
    #1 check(rdData, 8'h00, "R9 bus idle");

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      setPins(v[15:8]);
      if (v[26]) busWrite(v[25:24], v[23:16], 1'b1);
      else busReadCheck(v[25:24], v[7:0], $sformatf("R2/R3/R7/R8 vector %0d", i));
    end

    // R3 enables for split config: A out, B in, C hi out, C lo in
    busWrite(2'd3, 8'h83, 1'b1);
    @(negedge clk);
    check(pinOeA, 8'hFF, "R3 A enable");
    check(pinOeB, 8'h00, "R3 B enable");
    check(pinOeC, 8'hF0, "R11 C nibble enables");
    busWrite(2'd3, 8'h88, 1'b1);
    @(negedge clk);
    check(pinOeC, 8'h0F, "R11 C nibble enables swapped");
    check(pinOeB, 8'hFF, "R3 B enable output");

    // R4 latches cleared by config
    busWrite(2'd0, 8'hE7, 1'b1);
    busWrite(2'd3, 8'h80, 1'b1);
    @(negedge clk);
    check(pinOutA, 8'h00, "R4 latch cleared by config");

    // R10 write without chip select
    busWrite(2'd0, 8'h5C, 1'b0);
    busWrite(2'd3, 8'h9B, 1'b0);
    @(negedge clk);
    check(pinOutA, 8'h00, "R10 no-cs data write ignored");
    check(pinOeA, 8'hFF, "R10 no-cs config ignored");

    // R5 bad config leaves enables
    busWrite(2'd2, 8'h3E, 1'b1);
    busWrite(2'd3, 8'hDB, 1'b1);
    @(negedge clk);
    check(pinOeA, 8'hFF, "R5 enables kept");
    check(pinOutC, 8'h3E, "R5 latch kept");

    // R6 command bits 6:4 ignored, other lines kept
    busWrite(2'd3, 8'h70, 1'b1);
    @(negedge clk);
    check(pinOutC, 8'h3E, "R6 clear bit0 with junk upper bits");
    check(pinOeC, 8'hFF, "R6 direction untouched");

    // R7 live pins during a held read
    busWrite(2'd3, 8'h9B, 1'b1);
    @(negedge clk);
    cs = 1'b1; rdStrobe = 1'b1; addr = 2'd2;
    pinInC = 8'h12;
    #1 check(rdData, 8'h12, "R7 live read first value");
    pinInC = 8'hED;
    #1 check(rdData, 8'hED, "R7 live read follows pin");
    cs = 1'b0; rdStrobe = 1'b0;

    // R1 reset mid-run
    busWrite(2'd3, 8'h80, 1'b1);
    busWrite(2'd1, 8'hAA, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pinOeB, 8'h00, "R1 enables after reset again");
    check(pinOutB, 8'h00, "R1 latch after reset again");

    done = 1'b1;
    finishRun();
  end
endmodule